// File: doc/BRIEF.md
# Scanline Compare Interrupt and Multiplier Peripheral

This block is a small register-mapped peripheral for a cartridge mapper. It watches a per-scanline strobe from the video side. When the reported line equals a programmed target line and both sprite and background rendering are on, it raises a pending flag. That flag drives an active-high interrupt, gated by an enable bit. A status register also records whether the video side is inside the visible part of the frame. Reading the status register clears the pending flag. Vertical blank clears both status bits.

The same register window also holds an 8x8 unsigned multiplier. The CPU writes two operand registers and reads the 16-bit product back as a low byte and a high byte at adjacent offsets. Reads of any other address return the high byte of the address, which models open-bus behaviour.

The window sits at `BASE_ADDR`, and its size is set by `OFF_W`. The offsets are:

- Offset 0: target line (write).
- Offset 1: interrupt enable on write, status on read.
- Offset 2: operand A on write, product low byte on read.
- Offset 3: operand B on write, product high byte on read.

Top module: `scanline_irq_mul`

## Requirements
- R1: After reset, status reads 0x00, the product reads 0x0000 and `irq` is low.
- R2: A line strobe whose line number equals the target line, while `spr_on` and `bg_on` are both high, sets status bit 7 (pending) at the next clock edge.
- R3: A matching line strobe with either `spr_on` or `bg_on` low leaves the pending bit clear.
- R4: A line strobe whose line number differs from the target line leaves the pending bit unchanged.
- R5: A read of offset 1 returns {pending, in-frame, 6'b0} as it stands before the edge, and then clears the pending bit while leaving bit 6 alone.
- R6: A line strobe with a line number below `VISIBLE_LINES` (default 240) sets status bit 6 (in-frame); a strobe at line 240 or above does not set it.
- R7: A `vblank_stb` pulse clears status bits 7 and 6.
- R8: `irq` is high exactly while the pending bit is set and bit 7 of the last value written to offset 1 is 1; it follows a write to offset 1 one cycle later.
- R9: Offsets 2 and 3 read the low and high bytes of operand A times operand B, correct in the cycle after the operand write.
- R10: Reads of any offset other than 1, 2 or 3 return `cpu_addr[15:8]`.
- R11: A match in the same cycle as a status read or a vertical-blank pulse wins: the pending bit (and, for a visible line, bit 6) is set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | CPU address |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from the address |
| line_stb | input | 1 | One-cycle pulse per scanline |
| line_num | input | LINE_W | Line number carried by `line_stb` |
| vblank_stb | input | 1 | One-cycle pulse at the start of vertical blank |
| spr_on | input | 1 | Sprite rendering enabled |
| bg_on | input | 1 | Background rendering enabled |
| irq | output | 1 | Interrupt request, active high |

## Verification
The pending bit has one setter, the line match, and two clearers, the status read and vertical blank. Either clearer can land in the same cycle as the setter. The bench provokes each collision by driving a status read, or a `vblank_stb` pulse, in the same cycle as a matching line strobe. It then reads status again: the pending bit must still be set, so no interrupt is lost to a clear that raced it. The colliding read itself must return the pre-edge value.

// File: rtl/scanline_irq_mul.sv
module scanline_irq_mul #(
  parameter int ADDR_W        = 16,
  parameter logic [15:0] BASE_ADDR = 16'h5200,
  parameter int OFF_W         = 3,
  parameter int LINE_W        = 9,
  parameter int VISIBLE_LINES = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              line_stb,
  input  logic [LINE_W-1:0] line_num,
  input  logic              vblank_stb,
  input  logic              spr_on,
  input  logic              bg_on,
  output logic              irq
);

  localparam logic [OFF_W-1:0] OFF_TARGET = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_CTRL   = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_MUL_A  = OFF_W'(2);
  localparam logic [OFF_W-1:0] OFF_MUL_B  = OFF_W'(3);

  logic [7:0]  target_q, ctrl_q, mul_a_q, mul_b_q;
  logic        pend_q, frame_q;
  logic [15:0] product;

  wire [OFF_W-1:0] off = cpu_addr[OFF_W-1:0];
  wire hit      = cpu_addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W];
  wire wr_hit   = cpu_wr && hit;
  wire rd_stat  = cpu_rd && hit && (off == OFF_CTRL);
  wire visible  = line_stb && (line_num < LINE_W'(VISIBLE_LINES));
  wire match    = line_stb && spr_on && bg_on && (line_num == LINE_W'(target_q));

  assign product = 16'(mul_a_q) * 16'(mul_b_q);
  assign irq     = pend_q & ctrl_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      ctrl_q   <= '0;
      mul_a_q  <= '0;
      mul_b_q  <= '0;
    end else if (wr_hit) begin
      case (off)
        OFF_TARGET: target_q <= cpu_wdata;
        OFF_CTRL:   ctrl_q   <= cpu_wdata;
        OFF_MUL_A:  mul_a_q  <= cpu_wdata;
        OFF_MUL_B:  mul_b_q  <= cpu_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      if (match)                      pend_q <= 1'b1;
      else if (vblank_stb || rd_stat) pend_q <= 1'b0;
      if (visible)                    frame_q <= 1'b1;
      else if (vblank_stb)            frame_q <= 1'b0;
    end
  end

  always_comb begin
    cpu_rdata = cpu_addr[ADDR_W-1 -: 8];
    if (hit) begin
      case (off)
        OFF_CTRL:  cpu_rdata = {pend_q, frame_q, 6'b0};
        OFF_MUL_A: cpu_rdata = product[7:0];
        OFF_MUL_B: cpu_rdata = product[15:8];
        default: ;
      endcase
    end
  end

endmodule

module sirq_chk #(
  parameter int ADDR_W = 16,
  parameter logic [15:0] BASE_ADDR = 16'h5200,
  parameter int OFF_W  = 3,
  parameter int LINE_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [7:0]        cpu_wdata,
  input logic              line_stb,
  input logic [LINE_W-1:0] line_num,
  input logic              vblank_stb,
  input logic              spr_on,
  input logic              bg_on,
  input logic              irq,
  input logic              pend,
  input logic              frame,
  input logic [7:0]        target,
  input logic [7:0]        mul_a
);
  wire in_win  = cpu_addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W];
  wire at_ctrl = in_win && cpu_addr[OFF_W-1:0] == OFF_W'(1);
  wire at_a    = in_win && cpu_addr[OFF_W-1:0] == OFF_W'(2);
  wire hit_ln  = line_stb && spr_on && bg_on && line_num == LINE_W'(target);

  p_match_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ln |=> pend);
  p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !(spr_on && bg_on)) |=> !pend);
  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && at_ctrl && !hit_ln) |=> !pend);
  p_vbl_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_stb && !line_stb) |=> (!pend && !frame));
  p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && at_ctrl && !cpu_wdata[7]) |=> !irq);
  p_opa_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && at_a) |=> (mul_a == $past(cpu_wdata)));
endmodule

bind scanline_irq_mul sirq_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .OFF_W(OFF_W), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
  .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .line_stb(line_stb),
  .line_num(line_num), .vblank_stb(vblank_stb), .spr_on(spr_on),
  .bg_on(bg_on), .irq(irq), .pend(pend_q), .frame(frame_q),
  .target(target_q), .mul_a(mul_a_q)
);

// File: tb/tb_scanline_irq_mul.sv
module tb_scanline_irq_mul;
  localparam logic [15:0] BASE = 16'h5200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cpu_addr = BASE;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic line_stb = 1'b0, vblank_stb = 1'b0, spr_on = 1'b0, bg_on = 1'b0;
  logic [8:0] line_num = '0;
  logic irq;
  logic probe = 1'b0;

  int checks = 0, failures = 0;
  logic [7:0] q_exp[$];
  bit         q_irq[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  scanline_irq_mul dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .line_stb(line_stb), .line_num(line_num), .vblank_stb(vblank_stb),
    .spr_on(spr_on), .bg_on(bg_on), .irq(irq)
  );

  always @(negedge clk) begin
    if (cpu_rd || probe) begin
      if (q_exp.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty: got %02h expected an entry", cpu_rdata);
      end else begin
        logic [7:0] e;
        bit k;
        string t;
        logic [7:0] got;
        e = q_exp.pop_front();
        k = q_irq.pop_front();
        t = q_tag.pop_front();
        got = k ? {7'b0, irq} : cpu_rdata;
        checks++;
        if (got !== e) begin
          failures++;
          $display("FAIL %s: got %02h expected %02h", t, got, e);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    cpu_addr = BASE + 16'(off); cpu_wdata = d; cpu_wr = 1'b1;
    tick(); cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    q_exp.push_back(e); q_irq.push_back(1'b0); q_tag.push_back(t);
    cpu_addr = a; cpu_rd = 1'b1;
    tick(); cpu_rd = 1'b0;
  endtask

  task automatic chk_irq(input bit e, input string t);
    q_exp.push_back({7'b0, e}); q_irq.push_back(1'b1); q_tag.push_back(t);
    probe = 1'b1;
    tick(); probe = 1'b0;
  endtask

  task automatic line(input int n, input bit s, input bit b, input bit vb, input bit rd_too);
    line_stb = 1'b1; line_num = 9'(n); spr_on = s; bg_on = b; vblank_stb = vb;
    if (rd_too) begin
      q_exp.push_back(8'h00); q_irq.push_back(1'b0); q_tag.push_back("R11 read colliding with match");
      cpu_addr = BASE + 16'd1; cpu_rd = 1'b1;
    end
    tick();
    line_stb = 1'b0; vblank_stb = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic vbl();
    vblank_stb = 1'b1; tick(); vblank_stb = 1'b0;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(BASE + 16'd1, 8'h00, "R1 status after reset");
    rd(BASE + 16'd2, 8'h00, "R1 product low after reset");
    rd(BASE + 16'd3, 8'h00, "R1 product high after reset");
    chk_irq(1'b0, "R1 irq after reset");
    // R9 multiplier
    wr(3'd2, 8'd200); wr(3'd3, 8'd155);
    rd(BASE + 16'd2, 8'h18, "R9 200*155 low");
    rd(BASE + 16'd3, 8'h79, "R9 200*155 high");
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    rd(BASE + 16'd3, 8'hFE, "R9 255*255 high");
    rd(BASE + 16'd2, 8'h01, "R9 255*255 low");
    // R10 open bus
    rd(BASE + 16'd0, 8'h52, "R10 target offset reads open bus");
    rd(BASE + 16'd7, 8'h52, "R10 offset 7 open bus");
    // R6 / R7 in-frame bit
    line(10, 0, 0, 0, 0);
    rd(BASE + 16'd1, 8'h40, "R6 visible line sets bit6");
    vbl();
    rd(BASE + 16'd1, 8'h00, "R7 vblank clears bit6");
    line(240, 1, 1, 0, 0);
    rd(BASE + 16'd1, 8'h00, "R6 line 240 not visible");
    // R2 / R4 / R5 / R8 match path
    wr(3'd0, 8'd20); wr(3'd1, 8'h80);
    line(19, 1, 1, 0, 0);
    chk_irq(1'b0, "R4 non-matching line");
    rd(BASE + 16'd1, 8'h40, "R4 status after non-matching line");
    line(20, 1, 1, 0, 0);
    chk_irq(1'b1, "R8 irq with pending and enable");
    rd(BASE + 16'd1, 8'hC0, "R2 match sets pending");
    rd(BASE + 16'd1, 8'h40, "R5 read cleared pending, bit6 kept");
    chk_irq(1'b0, "R5 irq drops after status read");
    // R3 rendering gating
    line(20, 1, 0, 0, 0);
    rd(BASE + 16'd1, 8'h40, "R3 background off");
    line(20, 0, 1, 0, 0);
    rd(BASE + 16'd1, 8'h40, "R3 sprites off");
    // R8 enable gating
    wr(3'd1, 8'h00);
    line(20, 1, 1, 0, 0);
    chk_irq(1'b0, "R8 enable bit clear masks irq");
    wr(3'd1, 8'h80);
    chk_irq(1'b1, "R8 enable set with pending");
    wr(3'd1, 8'h7F);
    chk_irq(1'b0, "R8 only bit7 enables");
    // R7 vblank clears pending
    vbl();
    rd(BASE + 16'd1, 8'h00, "R7 vblank clears pending");
    // R11 collisions
    line(20, 1, 1, 0, 1);
    rd(BASE + 16'd1, 8'hC0, "R11 pending survives colliding read");
    vbl();
    line(20, 1, 1, 1, 0);
    rd(BASE + 16'd1, 8'hC0, "R11 match wins over vblank");
    repeat (2) tick();
    if (q_exp.size() != 0) begin
      failures++;
      $display("FAIL scoreboard leftover: got %0d expected 0", q_exp.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule